// File: doc/BRIEF.md
# Cache Line Invalidate Execution Unit

This unit carries out one privileged instruction that discards the cache line holding a given byte. It takes a 32-bit instruction word, the values of the two source registers it names, the two relocation bits of the machine state and a flag for user (problem) state. It forms an effective address. When data relocation is on, it translates that address through a request/response lookup port. It then asks both the instruction cache and the data cache to invalidate the line at the resulting real address. At the end it reports the result: it writes the address back to the register file, flags a fault, or raises a data storage interrupt.

The unit takes one instruction at a time. `issue_ready` is high only while the unit is idle, and every instruction, whether it acts or not, ends with a single-cycle `done` pulse. The lookup request and both cache invalidate requests are valid/ready handshakes. The lookup response is a single-cycle valid strobe. Addresses in a configurable I/O window never reach the caches.

Top module: `cli_exec_unit`

## Requirements
- R1: An instruction acts only when insn[31:26] equals 31 and insn[10:1] equals 502. In big-endian numbering the RA field is insn[20:16], RB is insn[15:11] and the record flag is insn[0]. Bits insn[25:21] have no effect. Any other word completes with `done` and takes no action.
- R2: When the RA field is nonzero the effective address is `opnd_a + opnd_b` (modulo 2^32). When the RA field is zero it is `opnd_b` alone.
- R3: With `msr_dr`=0 no lookup is requested and the effective address is used as the real address. `msr_ir` has no effect.
- R4: With `msr_dr`=1 exactly one lookup is requested. Its address is the effective address, and `xl_store`, `xl_no_prot`, `xl_no_lock` and `xl_set_ref` are all 1. On a hit, the real address is `xl_rsp_pa`.
- R5: If the lookup response has `xl_rsp_hit`=0, `dsi_irq` pulses together with `done` and `dsisr` becomes 32'h8000_0000. No invalidate is sent and no write-back occurs.
- R6: For a real address outside the I/O window, exactly one invalidate request goes to each cache, carrying the real address. Each request is held with a stable address until it is accepted, and `done` follows only after both have been accepted.
- R7: A real address with `(addr & IO_MASK) == IO_BASE` sends no invalidate. The write-back still happens.
- R8: When RA is nonzero and no interrupt occurred, `wb_valid` pulses with `done`, with `wb_idx`=RA and `wb_data` equal to the effective address. When RA is zero there is never a write-back.
- R9: When `problem_state`=1, a decoded instruction raises `priv_fault` with `done` and performs no lookup, invalidate, write-back or CR0 write.
- R10: When the record flag is 1 on an executed instruction, `cr0_we` pulses with `done`. The CR0 value written is unspecified; this unit writes zero.
- R11: `done` lasts exactly one cycle. `issue_ready` is high only when idle, and `issue_valid` has no effect while the unit is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit idle, instruction taken |
| insn | input | 32 | Instruction word |
| opnd_a | input | 32 | Value of register named by RA |
| opnd_b | input | 32 | Value of register named by RB |
| msr_dr | input | 1 | Data relocation enable |
| msr_ir | input | 1 | Instruction relocation (unused here) |
| problem_state | input | 1 | 1 when executing in user state |
| xl_req_valid | output | 1 | Lookup request valid |
| xl_req_ready | input | 1 | Lookup request accepted |
| xl_vaddr | output | 32 | Address to translate |
| xl_store | output | 1 | Access treated as store |
| xl_no_prot | output | 1 | Suppress protection check |
| xl_no_lock | output | 1 | Suppress data-lock check |
| xl_set_ref | output | 1 | Set page reference bit on a filled miss |
| xl_rsp_valid | input | 1 | Lookup response strobe |
| xl_rsp_hit | input | 1 | Translation exists |
| xl_rsp_pa | input | 32 | Translated real address |
| ic_inv_valid | output | 1 | Instruction cache invalidate request |
| ic_inv_ready | input | 1 | Instruction cache accepts |
| ic_inv_addr | output | 32 | Line address for instruction cache |
| dc_inv_valid | output | 1 | Data cache invalidate request |
| dc_inv_ready | input | 1 | Data cache accepts |
| dc_inv_addr | output | 32 | Line address for data cache |
| done | output | 1 | Completion pulse |
| wb_valid | output | 1 | Register write-back |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 32 | Write-back value |
| cr0_we | output | 1 | CR0 field write |
| cr0_val | output | 4 | CR0 value (unspecified, zero) |
| dsi_irq | output | 1 | Data storage interrupt pulse |
| dsisr | output | 32 | Interrupt status register |
| priv_fault | output | 1 | Privilege fault pulse |

## Verification
The operand table covers a range of cases. Some rows have RA nonzero and some have it zero, which separates the sum from the bare RB value, and one row wraps past 2^32. Others split relocation off from relocation on, with either a hit or a miss. The I/O window is reached both directly and only after translation, which shows that the window test uses the real address rather than the virtual one. A row in user state and a row with the record flag set isolate the privilege and CR0 paths. Directed cases cover a non-matching opcode, stray bits in the ignored field, one cache holding back its ready while the other accepts at once, and a second instruction offered while the unit is busy.

// File: rtl/cli_exec_unit.sv
module cli_exec_unit #(
  parameter int          DW      = 32,
  parameter logic [31:0] IO_MASK = 32'hF000_0000,
  parameter logic [31:0] IO_BASE = 32'hF000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  output logic          issue_ready,
  input  logic [31:0]   insn,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic          msr_dr,
  input  logic          msr_ir,
  input  logic          problem_state,
  output logic          xl_req_valid,
  input  logic          xl_req_ready,
  output logic [DW-1:0] xl_vaddr,
  output logic          xl_store,
  output logic          xl_no_prot,
  output logic          xl_no_lock,
  output logic          xl_set_ref,
  input  logic          xl_rsp_valid,
  input  logic          xl_rsp_hit,
  input  logic [DW-1:0] xl_rsp_pa,
  output logic          ic_inv_valid,
  input  logic          ic_inv_ready,
  output logic [DW-1:0] ic_inv_addr,
  output logic          dc_inv_valid,
  input  logic          dc_inv_ready,
  output logic [DW-1:0] dc_inv_addr,
  output logic          done,
  output logic          wb_valid,
  output logic [4:0]    wb_idx,
  output logic [DW-1:0] wb_data,
  output logic          cr0_we,
  output logic [3:0]    cr0_val,
  output logic          dsi_irq,
  output logic [31:0]   dsisr,
  output logic          priv_fault
);

  localparam logic [5:0] PRIMARY = 6'd31;
  localparam logic [9:0] EXTOP   = 10'd502;

  typedef enum logic [2:0] {ST_IDLE, ST_XREQ, ST_XWAIT, ST_INV, ST_DONE} st_t;

  st_t           st;
  logic [DW-1:0] ea_q, pa_q;
  logic [4:0]    ra_q;
  logic          rc_q, act_q, dsi_q, pf_q, ic_pend, dc_pend;
  logic [31:0]   dsisr_q;

  logic [4:0]    ra_f;
  logic          match, take;
  logic [DW-1:0] ea_calc;
  logic          ic_left, dc_left;
  logic          unused_ok;

  assign ra_f    = insn[20:16];
  assign match   = (insn[31:26] == PRIMARY) && (insn[10:1] == EXTOP);
  assign ea_calc = ((ra_f != 5'd0) ? opnd_a : '0) + opnd_b;
  assign take    = issue_valid && (st == ST_IDLE);
  assign ic_left = ic_pend && !ic_inv_ready;
  assign dc_left = dc_pend && !dc_inv_ready;
  assign unused_ok = ^{insn[25:21], msr_ir};

  function automatic logic in_io(input logic [DW-1:0] a);
    in_io = ((a & IO_MASK) == IO_BASE);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ea_q    <= '0;
      pa_q    <= '0;
      ra_q    <= '0;
      rc_q    <= 1'b0;
      act_q   <= 1'b0;
      dsi_q   <= 1'b0;
      pf_q    <= 1'b0;
      ic_pend <= 1'b0;
      dc_pend <= 1'b0;
      dsisr_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          ea_q  <= ea_calc;
          pa_q  <= ea_calc;
          ra_q  <= ra_f;
          rc_q  <= insn[0];
          act_q <= match && !problem_state;
          pf_q  <= match && problem_state;
          dsi_q <= 1'b0;
          if (!match || problem_state) st <= ST_DONE;
          else if (msr_dr)             st <= ST_XREQ;
          else if (in_io(ea_calc))     st <= ST_DONE;
          else begin
            st      <= ST_INV;
            ic_pend <= 1'b1;
            dc_pend <= 1'b1;
          end
        end
        ST_XREQ: if (xl_req_ready) st <= ST_XWAIT;
        ST_XWAIT: if (xl_rsp_valid) begin
          if (!xl_rsp_hit) begin
            dsi_q   <= 1'b1;
            dsisr_q <= 32'h8000_0000;
            st      <= ST_DONE;
          end else begin
            pa_q <= xl_rsp_pa;
            if (in_io(xl_rsp_pa)) st <= ST_DONE;
            else begin
              st      <= ST_INV;
              ic_pend <= 1'b1;
              dc_pend <= 1'b1;
            end
          end
        end
        ST_INV: begin
          ic_pend <= ic_left;
          dc_pend <= dc_left;
          if (!ic_left && !dc_left) st <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign issue_ready  = (st == ST_IDLE);
  assign xl_req_valid = (st == ST_XREQ);
  assign xl_vaddr     = ea_q;
  assign xl_store     = 1'b1;
  assign xl_no_prot   = 1'b1;
  assign xl_no_lock   = 1'b1;
  assign xl_set_ref   = 1'b1;
  assign ic_inv_valid = (st == ST_INV) && ic_pend;
  assign dc_inv_valid = (st == ST_INV) && dc_pend;
  assign ic_inv_addr  = pa_q;
  assign dc_inv_addr  = pa_q;
  assign done         = (st == ST_DONE);
  assign wb_valid     = done && act_q && !dsi_q && (ra_q != 5'd0);
  assign wb_idx       = ra_q;
  assign wb_data      = ea_q;
  assign cr0_we       = done && act_q && rc_q;
  assign cr0_val      = 4'd0;
  assign dsi_irq      = done && dsi_q;
  assign dsisr        = dsisr_q;
  assign priv_fault   = done && pf_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  ic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ic_inv_valid && !ic_inv_ready |=> ic_inv_valid && $stable(ic_inv_addr));
  // R6
  dc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dc_inv_valid && !dc_inv_ready |=> dc_inv_valid && $stable(dc_inv_addr));
  // R5
  dsi_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsi_irq |-> dsisr[31] && !wb_valid && !ic_inv_valid && !dc_inv_valid);
  // R9
  priv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> !wb_valid && !cr0_we && !dsi_irq);
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_ready && !done |=> !issue_ready);

endmodule

// File: tb/tb_cli_exec_unit.sv
module tb_cli_exec_unit;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic issue_valid = 0, issue_ready;
  logic [31:0] insn = 0, opnd_a = 0, opnd_b = 0;
  logic msr_dr = 0, msr_ir = 0, problem_state = 0;
  logic xl_req_valid, xl_req_ready = 1;
  logic [31:0] xl_vaddr;
  logic xl_store, xl_no_prot, xl_no_lock, xl_set_ref;
  logic xl_rsp_valid = 0, xl_rsp_hit = 0;
  logic [31:0] xl_rsp_pa = 0;
  logic ic_inv_valid, ic_inv_ready = 1, dc_inv_valid, dc_inv_ready = 1;
  logic [31:0] ic_inv_addr, dc_inv_addr;
  logic done, wb_valid, cr0_we, dsi_irq, priv_fault;
  logic [4:0] wb_idx;
  logic [31:0] wb_data, dsisr;
  logic [3:0] cr0_val;

  cli_exec_unit dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic cur_hit = 0;
  logic [31:0] cur_pa = 0;

  int n_done, n_xl, n_ic, n_dc, n_wb, n_dsi, n_pf, n_cr0;
  logic [31:0] xl_a, ic_a, dc_a, wb_d;
  logic [4:0] wb_i;
  logic xl_attr;

  task automatic clr_mon();
    n_done = 0; n_xl = 0; n_ic = 0; n_dc = 0; n_wb = 0; n_dsi = 0; n_pf = 0; n_cr0 = 0;
    xl_a = 0; ic_a = 0; dc_a = 0; wb_d = 0; wb_i = 0; xl_attr = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    xl_rsp_valid <= 1'b0;
    if (xl_req_valid && xl_req_ready) begin
      xl_rsp_valid <= 1'b1;
      xl_rsp_hit   <= cur_hit;
      xl_rsp_pa    <= cur_pa;
      n_xl++; xl_a = xl_vaddr;
      xl_attr = xl_store && xl_no_prot && xl_no_lock && xl_set_ref;
    end
    if (ic_inv_valid && ic_inv_ready) begin n_ic++; ic_a = ic_inv_addr; end
    if (dc_inv_valid && dc_inv_ready) begin n_dc++; dc_a = dc_inv_addr; end
    if (done) n_done++;
    if (wb_valid) begin n_wb++; wb_i = wb_idx; wb_d = wb_data; end
    if (dsi_irq) n_dsi++;
    if (priv_fault) n_pf++;
    if (cr0_we) n_cr0++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] ra, input logic [4:0] rb, input logic rc,
                                     input logic [4:0] junk);
    mk = {6'd31, junk, ra, rb, 10'd502, rc};
  endfunction

  typedef struct packed {
    logic [4:0] ra; logic [4:0] rb; logic rc;
    logic [31:0] a; logic [31:0] b;
    logic dr; logic ir; logic hit; logic [31:0] pa; logic priv;
    logic [31:0] ea; logic inv; logic wb; logic dsi;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  5'd4,  1'b0, 32'h0000_1000, 32'h0000_0020, 1'b0, 1'b0, 1'b0, 32'h0,          1'b0, 32'h0000_1020, 1'b1, 1'b1, 1'b0},
    '{5'd0,  5'd5,  1'b1, 32'hDEAD_0000, 32'h0000_2040, 1'b0, 1'b1, 1'b0, 32'h0,          1'b0, 32'h0000_2040, 1'b1, 1'b0, 1'b0},
    '{5'd7,  5'd8,  1'b0, 32'h4000_0000, 32'h0000_0100, 1'b1, 1'b0, 1'b1, 32'h0080_0100, 1'b0, 32'h4000_0100, 1'b1, 1'b1, 1'b0},
    '{5'd9,  5'd1,  1'b0, 32'h5000_0000, 32'h0000_0004, 1'b1, 1'b1, 1'b0, 32'h0,          1'b0, 32'h5000_0004, 1'b0, 1'b0, 1'b1},
    '{5'd2,  5'd3,  1'b0, 32'hF000_0000, 32'h0000_0010, 1'b0, 1'b0, 1'b0, 32'h0,          1'b0, 32'hF000_0010, 1'b0, 1'b1, 1'b0},
    '{5'd4,  5'd6,  1'b1, 32'h1234_0000, 32'h0000_0008, 1'b1, 1'b0, 1'b1, 32'hF100_0008, 1'b0, 32'h1234_0008, 1'b0, 1'b1, 1'b0},
    '{5'd31, 5'd31, 1'b0, 32'hFFFF_FFF0, 32'h0000_0020, 1'b0, 1'b0, 1'b0, 32'h0,          1'b0, 32'h0000_0010, 1'b1, 1'b1, 1'b0},
    '{5'd3,  5'd4,  1'b1, 32'h0000_0001, 32'h0000_0002, 1'b1, 1'b0, 1'b1, 32'h0000_0003, 1'b1, 32'h0000_0003, 1'b0, 1'b0, 1'b0}
  };

  task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                       input logic dr, input logic ir, input logic pr);
    clr_mon();
    @(negedge clk);
    insn = w; opnd_a = a; opnd_b = b; msr_dr = dr; msr_ir = ir; problem_state = pr;
    issue_valid = 1;
    @(negedge clk);
    issue_valid = 0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 60 && n_done == 0; k++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    clr_mon();
    repeat (3) @(negedge clk);
    // reset state (R11, R5)
    chk(issue_ready === 1'b1, "R11 reset ready", {31'd0, issue_ready}, 32'd1);
    chk(done === 1'b0 && ic_inv_valid === 1'b0 && dc_inv_valid === 1'b0 && xl_req_valid === 1'b0,
        "R11 reset outputs idle", {28'd0, done, ic_inv_valid, dc_inv_valid, xl_req_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(dsisr === 32'd0, "R5 reset dsisr", dsisr, 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      logic [31:0] real_a = v.dr ? v.pa : v.ea;
      cur_hit = v.hit; cur_pa = v.pa;
      issue(mk(v.ra, v.rb, v.rc, 5'd0), v.a, v.b, v.dr, v.ir, v.priv);
      wait_done();
      chk(n_done == 1, "R11 one done", n_done, 1);
      chk(n_xl == int'(v.dr && !v.priv), "R3 R4 lookup count", n_xl, {31'd0, v.dr && !v.priv});
      if (n_xl == 1) begin
        chk(xl_a == v.ea, "R2 R4 lookup address", xl_a, v.ea);
        chk(xl_attr == 1'b1, "R4 store and suppress flags", {31'd0, xl_attr}, 32'd1);
      end
      chk(n_ic == int'(v.inv) && n_dc == int'(v.inv), "R6 R7 invalidate count",
          n_ic * 16 + n_dc, v.inv * 17);
      if (v.inv) begin
        chk(ic_a == real_a, "R6 icache address", ic_a, real_a);
        chk(dc_a == real_a, "R6 dcache address", dc_a, real_a);
      end
      chk(n_wb == int'(v.wb), "R8 writeback count", n_wb, {31'd0, v.wb});
      if (v.wb) chk(wb_d == v.ea && wb_i == v.ra, "R2 R8 writeback value", wb_d, v.ea);
      chk(n_dsi == int'(v.dsi), "R5 interrupt", n_dsi, {31'd0, v.dsi});
      if (v.dsi) chk(dsisr == 32'h8000_0000, "R5 status msb", dsisr, 32'h8000_0000);
      chk(n_pf == int'(v.priv), "R9 privilege fault", n_pf, {31'd0, v.priv});
      chk(n_cr0 == int'(v.rc && !v.priv), "R10 cr0 write", n_cr0, {31'd0, v.rc && !v.priv});
    end

    // R1: wrong extended opcode -> no action
    issue({6'd31, 5'd0, 5'd3, 5'd4, 10'd501, 1'b1}, 32'h100, 32'h200, 1'b0, 1'b0, 1'b0);
    wait_done();
    chk(n_done == 1 && n_ic == 0 && n_wb == 0 && n_cr0 == 0 && n_pf == 0, "R1 non-matching word",
        n_ic + n_wb + n_cr0 + n_pf, 0);
    // R1: wrong primary opcode in user state -> no fault
    issue({6'd30, 5'd0, 5'd3, 5'd4, 10'd502, 1'b0}, 32'h100, 32'h200, 1'b0, 1'b0, 1'b1);
    wait_done();
    chk(n_done == 1 && n_pf == 0 && n_ic == 0, "R1 wrong primary no fault", n_pf + n_ic, 0);
    // R1: stray bits in ignored field
    issue(mk(5'd6, 5'd7, 1'b0, 5'b10101), 32'h0000_3000, 32'h0000_0040, 1'b0, 1'b0, 1'b0);
    wait_done();
    chk(n_ic == 1 && ic_a == 32'h0000_3040 && n_wb == 1, "R1 ignored bits", ic_a, 32'h0000_3040);

    // R6: icache holds ready low, dcache accepts immediately
    ic_inv_ready = 0;
    issue(mk(5'd5, 5'd2, 1'b0, 5'd0), 32'h0000_8000, 32'h0000_0080, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk(n_dc == 1 && n_ic == 0 && n_done == 0 && ic_inv_valid && ic_inv_addr == 32'h0000_8080,
        "R6 wait for both caches", ic_inv_addr, 32'h0000_8080);
    ic_inv_ready = 1;
    wait_done();
    chk(n_ic == 1 && n_dc == 1 && n_done == 1, "R6 single accept each", n_ic + n_dc, 2);

    // R11: second instruction offered while busy is ignored
    ic_inv_ready = 0;
    clr_mon();
    @(negedge clk);
    insn = mk(5'd11, 5'd12, 1'b0, 5'd0); opnd_a = 32'h10; opnd_b = 32'h20;
    msr_dr = 0; problem_state = 0; issue_valid = 1;
    @(negedge clk);
    insn = mk(5'd13, 5'd12, 1'b1, 5'd0); opnd_a = 32'h900;
    @(negedge clk);
    chk(issue_ready === 1'b0, "R11 not ready while busy", {31'd0, issue_ready}, 32'd0);
    @(negedge clk);
    issue_valid = 0;
    ic_inv_ready = 1;
    wait_done();
    repeat (3) @(negedge clk);
    chk(n_done == 1 && wb_i == 5'd11 && wb_d == 32'h30 && n_cr0 == 0, "R11 busy input ignored",
        {27'd0, wb_i}, 32'd11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule